// File: doc/BRIEF.md
# Nanosecond-to-Cycle Timing Calculator

This block turns a set of external static-memory timing requirements, each given in nanoseconds, into whole clock-cycle counts for a controller running at a known frequency. A request supplies the controller clock rate in Hz and fourteen nanosecond values. These are the setup and pulse widths of the chip select and of the strobe for both reads and writes, the total read and write cycle times, and four recovery times. The block returns ten cycle counts. The read and write totals are stretched so that each setup-plus-pulse-plus-recovery sequence fits inside them.

The conversion first derives a 16.16 fixed-point cycles-per-nanosecond factor from the clock rate, using a shared sequential divider. It then converts each value with rounding up, one value per cycle through a single multiplier. Finally it stretches the totals and clips every count to the width of the field it is meant for. A one-cycle `start` launches a computation. A one-cycle `done` marks valid results, which then hold until the next result is ready.

Top module: `nsc_timing_calc`

## Requirements
- R1: The scale factor equals ((clk_hz / 10000) * 65536) / 100000, with both divisions truncating. It is taken from the clock rate sampled with `start`.
- R2: A nonzero time x converts to (x * scale + 65535) / 65536, truncated, so any fraction of a cycle rounds up.
- R3: A requested time of zero yields a count of zero.
- R4: A recovery time of zero counts as one cycle, and a nonzero recovery time is converted as in R2. Recovery inputs are t_ns indices 10 (chip-select read), 11 (read strobe), 12 (chip-select write) and 13 (write strobe).
- R5: Output 8, the read total, is the largest of three values: the converted t_ns[8]; t_ns[0]+t_ns[4]+recovery 10; and t_ns[1]+t_ns[5]+recovery 11. The inputs are indexed as follows: 0 chip-select read setup, 1 read-strobe setup, 4 chip-select read pulse, 5 read-strobe pulse, 8 read total.
- R6: Output 9, the write total, is the largest of three values: the converted t_ns[9]; t_ns[2]+t_ns[6]+recovery 12; and t_ns[3]+t_ns[7]+recovery 13. The inputs are indexed as follows: 2 chip-select write setup, 3 write-strobe setup, 6 chip-select write pulse, 7 write-strobe pulse, 9 write total.
- R7: Output i, for i from 0 to 9, carries the value computed for index i. A value above its field maximum is clipped to that maximum and sets sat[i]. The maximum is 63 for outputs 0 to 3, 127 for outputs 4 to 7 and 511 for outputs 8 and 9.
- R8: `done` is high for exactly one cycle per accepted `start`. Outputs and `sat` change only in that cycle. A `start` raised while a computation is running is ignored.
- R9: `clk_hz` and `t_ns` are sampled only in the cycle in which `start` is accepted. Later changes do not affect that result.
- R10: After reset, `cyc_out` and `sat` are all zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches a computation when the block is idle |
| clk_hz | input | 32 | Controller clock frequency in Hz |
| t_ns | input | 14x16 | Timing requests in ns, indexed as in R4 to R6 |
| cyc_out | output | 10x9 | Cycle counts, indexed as in R7 |
| sat | output | 10 | Per-output clip flags |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle. The bench raises `start` with fresh operands in the very cycle `done` is high, so that every request after the first arrives back to back. It judges the overlap in three ways. A scoreboard result must appear for each request, in order. `done` must never last two cycles. The outputs must not move between pulses. Between requests the bench also scrambles the operands and raises a stray `start` while the block is busy. A design that resampled its inputs or accepted the stray start would produce a result that does not match the queued one.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  localparam int NUM_T     = 14;  // nanosecond inputs
  localparam int NUM_O     = 10;  // cycle-count outputs
  localparam int IX_RD_TOT = 8;
  localparam int IX_WR_TOT = 9;
  localparam int IX_REC0   = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV1, ST_DIV2, ST_CONV, ST_FIN
  } nsc_state_e;

  // width of the destination field for output index idx
  function automatic int field_width(int idx, int setup_w, int pulse_w, int total_w);
    if (idx < 4)      return setup_w;
    else if (idx < 8) return pulse_w;
    else              return total_w;
  endfunction
endpackage

// File: rtl/nsc_seqdiv.sv
// Restoring divider, one quotient bit per cycle.
module nsc_seqdiv #(
  parameter int DW = 48,
  parameter int VW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          ready
);
  localparam int CNTW = $clog2(DW + 1);

  logic [VW-1:0]   rem_q, rem_d;
  logic [DW-1:0]   quo_q, quo_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            run_q, run_d;
  logic            rdy_q, rdy_d;
  logic [VW:0]     trial;

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    cnt_d = cnt_q;
    run_d = run_q;
    rdy_d = 1'b0;
    trial = {rem_q, quo_q[DW-1]};
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      cnt_d = CNTW'(DW);
      run_d = 1'b1;
    end else if (run_q) begin
      if (trial >= {1'b0, divisor}) begin
        rem_d = VW'(trial - {1'b0, divisor});
        quo_d = {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_d = VW'(trial);
        quo_d = {quo_q[DW-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        run_d = 1'b0;
        rdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      rdy_q <= rdy_d;
    end
  end

  assign quotient = quo_q;
  assign ready    = rdy_q;

  // R1: every division runs the full quotient length
  assert_div_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cnt_q == CNTW'(DW));
  // R1: ready only once the iteration has stopped
  assert_div_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> !run_q);
endmodule

// File: rtl/nsc_ns2cyc.sv
// Fixed-point ns to cycle conversion with round-up.
module nsc_ns2cyc #(
  parameter int NSW  = 16,
  parameter int SW   = 20,
  parameter int FRAC = 16,
  parameter int RW   = NSW + SW + 1 - FRAC
) (
  input  logic [NSW-1:0] ns,
  input  logic [SW-1:0]  scale,
  output logic [RW-1:0]  cyc
);
  localparam int PW = NSW + SW + 1;

  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(ns) * PW'(scale) + PW'((1 << FRAC) - 1);
    cyc  = (ns == '0) ? '0 : prod[PW-1:FRAC];
  end
endmodule

// File: rtl/nsc_timing_calc.sv
module nsc_timing_calc
  import nsc_pkg::*;
#(
  parameter int NSW       = 16,
  parameter int FW        = 32,
  parameter int SETUP_W   = 6,
  parameter int PULSE_W   = 7,
  parameter int TOT_W     = 9,
  parameter int SW        = 20,
  parameter int FRAC      = 16,
  parameter int HZ_DIV    = 10000,
  parameter int SCALE_DIV = 100000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [FW-1:0]                    clk_hz,
  input  logic [NUM_T-1:0][NSW-1:0]        t_ns,
  output logic [NUM_O-1:0][TOT_W-1:0]      cyc_out,
  output logic [NUM_O-1:0]                 sat,
  output logic                             done
);
  localparam int DW   = FW + FRAC;
  localparam int VW   = $clog2(SCALE_DIV + 1);
  localparam int RW   = NSW + SW + 1 - FRAC;
  localparam int SUMW = RW + 2;
  localparam int IDXW = $clog2(NUM_T);

  // reset synchroniser
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  nsc_state_e                   st_q, st_d;
  logic                         go_q, go_d;
  logic                         cap_en, scale_en, raw_en, out_en;
  logic [FW-1:0]                cap_hz_q;
  logic [NUM_T-1:0][NSW-1:0]    cap_ns_q;
  logic [SW-1:0]                scale_q;
  logic [IDXW-1:0]              idx_q, idx_d;
  logic [NUM_T-1:0][RW-1:0]     raw_q;
  logic [NUM_O-1:0][TOT_W-1:0]  cyc_q, cyc_d;
  logic [NUM_O-1:0]             sat_q, sat_d;
  logic                         done_q;

  logic [DW-1:0] div_dividend, div_quo;
  logic [VW-1:0] div_divisor;
  logic          div_rdy;
  logic [RW-1:0] conv_cyc;

  // shared divider: first clk_hz / HZ_DIV, then (q << FRAC) / SCALE_DIV
  always_comb begin
    if (st_q == ST_DIV2) begin
      div_dividend = {div_quo[FW-1:0], {FRAC{1'b0}}};
      div_divisor  = VW'(SCALE_DIV);
    end else begin
      div_dividend = DW'(cap_hz_q);
      div_divisor  = VW'(HZ_DIV);
    end
  end

  nsc_seqdiv #(.DW(DW), .VW(VW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (go_q),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .quotient (div_quo),
    .ready    (div_rdy)
  );

  nsc_ns2cyc #(.NSW(NSW), .SW(SW), .FRAC(FRAC), .RW(RW)) u_conv (
    .ns    (cap_ns_q[idx_q]),
    .scale (scale_q),
    .cyc   (conv_cyc)
  );

  // sequencer next state
  always_comb begin
    st_d     = st_q;
    go_d     = 1'b0;
    idx_d    = idx_q;
    cap_en   = 1'b0;
    scale_en = 1'b0;
    raw_en   = 1'b0;
    out_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        cap_en = 1'b1;
        go_d   = 1'b1;
        st_d   = ST_DIV1;
      end
      ST_DIV1: if (div_rdy) begin
        go_d = 1'b1;
        st_d = ST_DIV2;
      end
      ST_DIV2: if (div_rdy) begin
        scale_en = 1'b1;
        idx_d    = '0;
        st_d     = ST_CONV;
      end
      ST_CONV: begin
        raw_en = 1'b1;
        if (idx_q == IDXW'(NUM_T - 1)) begin
          idx_d = '0;
          st_d  = ST_FIN;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_FIN: begin
        out_en = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // stretching of the two totals
  logic [3:0][RW-1:0] rec_eff;
  logic [SUMW-1:0]    rd_a, rd_b, wr_a, wr_b, rd_need, wr_need;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rec_eff[i] = (cap_ns_q[IX_REC0 + i] == '0) ? RW'(1) : raw_q[IX_REC0 + i];
    end
    rd_a = SUMW'(raw_q[0]) + SUMW'(raw_q[4]) + SUMW'(rec_eff[0]);
    rd_b = SUMW'(raw_q[1]) + SUMW'(raw_q[5]) + SUMW'(rec_eff[1]);
    wr_a = SUMW'(raw_q[2]) + SUMW'(raw_q[6]) + SUMW'(rec_eff[2]);
    wr_b = SUMW'(raw_q[3]) + SUMW'(raw_q[7]) + SUMW'(rec_eff[3]);
    rd_need = SUMW'(raw_q[IX_RD_TOT]);
    if (rd_a > rd_need) rd_need = rd_a;
    if (rd_b > rd_need) rd_need = rd_b;
    wr_need = SUMW'(raw_q[IX_WR_TOT]);
    if (wr_a > wr_need) wr_need = wr_a;
    if (wr_b > wr_need) wr_need = wr_b;
  end

  // clip each output to its field
  for (genvar g = 0; g < NUM_O; g++) begin : g_clip
    localparam int GW = field_width(g, SETUP_W, PULSE_W, TOT_W);
    localparam logic [SUMW-1:0] LIM = SUMW'((1 << GW) - 1);
    logic [SUMW-1:0] val;
    if (g == IX_RD_TOT) begin : g_rd
      assign val = rd_need;
    end else if (g == IX_WR_TOT) begin : g_wr
      assign val = wr_need;
    end else begin : g_plain
      assign val = SUMW'(raw_q[g]);
    end
    assign sat_d[g] = (val > LIM);
    assign cyc_d[g] = sat_d[g] ? TOT_W'(LIM) : TOT_W'(val);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= ST_IDLE;
      go_q     <= 1'b0;
      idx_q    <= '0;
      cap_hz_q <= '0;
      cap_ns_q <= '0;
      scale_q  <= '0;
      raw_q    <= '0;
      cyc_q    <= '0;
      sat_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      go_q   <= go_d;
      idx_q  <= idx_d;
      done_q <= out_en;
      if (cap_en) begin
        cap_hz_q <= clk_hz;
        cap_ns_q <= t_ns;
      end
      if (scale_en) scale_q <= div_quo[SW-1:0];
      if (raw_en)   raw_q[idx_q] <= conv_cyc;
      if (out_en) begin
        cyc_q <= cyc_d;
        sat_q <= sat_d;
      end
    end
  end

  assign cyc_out = cyc_q;
  assign sat     = sat_q;
  assign done    = done_q;

  // R1: the derived factor fits the scale register
  assert_scale_fits_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    scale_en |-> div_quo[DW-1:SW] == '0);
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |=> !done_q);
  // R8: results hold between pulses
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done_q |-> $stable(cyc_q) && $stable(sat_q));
  // R3: a zero request gives a zero count
  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q && cap_ns_q[0] == '0 |-> cyc_q[0] == '0);
  // R5: read total covers chip-select setup plus pulse
  assert_rd_cover_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q && !sat_q[IX_RD_TOT] |->
      SUMW'(cyc_q[IX_RD_TOT]) >= SUMW'(cyc_q[0]) + SUMW'(cyc_q[4]));
  // R6: write total covers strobe setup plus pulse
  assert_wr_cover_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q && !sat_q[IX_WR_TOT] |->
      SUMW'(cyc_q[IX_WR_TOT]) >= SUMW'(cyc_q[3]) + SUMW'(cyc_q[7]));
endmodule

// File: tb/tb_nsc_timing_calc.sv
module tb_nsc_timing_calc;
  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [31:0]         clk_hz = '0;
  logic [13:0][15:0]   t_ns = '0;
  logic [9:0][8:0]     cyc_out;
  logic [9:0]          sat;
  logic                done;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [9:0][8:0] c;
    logic [9:0]      s;
    logic [31:0]     tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  nsc_timing_calc dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .clk_hz  (clk_hz),
    .t_ns    (t_ns),
    .cyc_out (cyc_out),
    .sat     (sat),
    .done    (done)
  );

  function automatic longint unsigned cv(longint unsigned x, longint unsigned sc);
    return (x == 0) ? 64'd0 : ((x * sc + 64'd65535) >> 16);
  endfunction

  // model of R1..R7
  function automatic exp_t ref_calc(logic [31:0] hz, logic [13:0][15:0] t, logic [31:0] tag);
    exp_t e;
    longint unsigned h, sc, rd, wr, v, lim;
    longint unsigned r[14];
    h  = hz;
    sc = ((h / 10000) << 16) / 100000;
    for (int i = 0; i < 14; i++) begin
      r[i] = cv(t[i], sc);
      if (i >= 10 && t[i] == 0) r[i] = 1;
    end
    rd = r[8];
    if (r[0] + r[4] + r[10] > rd) rd = r[0] + r[4] + r[10];
    if (r[1] + r[5] + r[11] > rd) rd = r[1] + r[5] + r[11];
    wr = r[9];
    if (r[2] + r[6] + r[12] > wr) wr = r[2] + r[6] + r[12];
    if (r[3] + r[7] + r[13] > wr) wr = r[3] + r[7] + r[13];
    for (int o = 0; o < 10; o++) begin
      v   = (o == 8) ? rd : (o == 9) ? wr : r[o];
      lim = (o < 4) ? 63 : (o < 8) ? 127 : 511;
      e.s[o] = (v > lim);
      e.c[o] = (v > lim) ? 9'(lim) : 9'(v);
    end
    e.tag = tag;
    return e;
  endfunction

  // driver: queue expectation, launch, scramble while busy, wait for completion
  task automatic run_case(input logic [31:0] hz, input logic [13:0][15:0] t, input logic [31:0] tag);
    exp_q.push_back(ref_calc(hz, t, tag));
    clk_hz = hz;
    t_ns   = t;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    clk_hz = $urandom;                 // R9: ignored after acceptance
    for (int i = 0; i < 14; i++) t_ns[i] = 16'($urandom);
    @(negedge clk);
    start = 1'b1;                      // R8: stray start while busy
    @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  // monitor: scoreboard compare and pulse/hold checks
  initial begin : monitor
    logic            prev_done;
    logic            hold_bad;
    logic [9:0][8:0] last_c;
    logic [9:0]      last_s;
    exp_t            e;
    prev_done = 1'b0;
    hold_bad  = 1'b0;
    last_c    = '0;
    last_s    = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done && prev_done) begin
          checks++; fails++;
          $display("FAIL R8 done high two cycles: actual 1 expected 0");
        end
        if (!done && (cyc_out != last_c || sat != last_s)) hold_bad = 1'b1;
        if (done && !prev_done) begin
          checks++;
          if (hold_bad) begin
            fails++;
            $display("FAIL R8 outputs moved between pulses: actual changed expected stable");
          end
          hold_bad = 1'b0;
          if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R8 done without accepted start: actual 1 expected 0");
          end else begin
            e = exp_q.pop_front();
            for (int o = 0; o < 10; o++) begin
              checks++;
              if (cyc_out[o] !== e.c[o]) begin
                fails++;
                $display("FAIL %s (case %s) output %0d: actual %0d expected %0d",
                         (o == 8) ? "R5" : (o == 9) ? "R6" : "R2", e.tag, o, cyc_out[o], e.c[o]);
              end
            end
            checks++;
            if (sat !== e.s) begin
              fails++;
              $display("FAIL R7 (case %s) sat: actual %b expected %b", e.tag, sat, e.s);
            end
          end
          last_c = cyc_out;
          last_s = sat;
        end
        prev_done = done;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [13:0][15:0] t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    checks++;
    if (cyc_out !== '0 || sat !== '0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset state: actual %h/%h/%b expected 0/0/0", cyc_out, sat, done);
    end

    // R1 R2: 100 MHz, mixed values and recoveries
    t = '0;
    t[0] = 5;  t[1] = 10; t[2] = 0;  t[3] = 15;
    t[4] = 40; t[5] = 35; t[6] = 50; t[7] = 45;
    t[8] = 60; t[9] = 0;
    t[10] = 0; t[11] = 20; t[12] = 10; t[13] = 0;
    run_case(32'd100_000_000, t, "R1");

    // R3 R4: all zero requests, totals fall back to one-cycle recovery
    run_case(32'd50_000_000, '0, "R3");

    // R4: scale of zero, nonzero read recoveries convert to zero
    t = '0;
    t[0] = 100; t[10] = 50; t[11] = 70;
    run_case(32'd5000, t, "R4");

    // R7: saturation together with stretching at 250 MHz
    t = '0;
    t[0] = 200;  t[4] = 2000; t[1] = 300; t[5] = 600;
    t[3] = 100;  t[7] = 40;   t[9] = 30;  t[13] = 400;
    run_case(32'd250_000_000, t, "R7");

    // R2: rounding at an awkward clock
    t = '0;
    for (int i = 0; i < 14; i++) t[i] = 16'(7 + 13 * i);
    run_case(32'd33_333_333, t, "R2");

    // R9: random requests, each followed by scrambled inputs while busy
    for (int k = 0; k < 20; k++) begin
      logic [31:0] hz;
      hz = 32'd1_000_000 + ($urandom % 32'd249_000_000);
      for (int i = 0; i < 14; i++) begin
        t[i] = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom % ((k < 10) ? 200 : 65536));
      end
      run_case(hz, t, "R9");
    end

    // R8: no further completion without a start
    repeat (300) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 results missing: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule